// File: doc/BRIEF.md
# Integer Flag and Condition Generator

This block derives the status flags that follow a 64-bit integer ALU operation. It takes the two source operands, an optional immediate that stands in for the second operand, an invert control for the first operand, the ALU result and a set of per-operation enables. From these it computes the full-width and low-half carry, the full-width and low-half overflow, a sticky summary-overflow bit and a four-bit signed-compare condition field. The arithmetic itself happens elsewhere. This block only looks at what went in and what came out.

All flags live in registers inside the block, and those registers are the architectural flag state. An operation is offered with a one-cycle `in_valid` pulse. One clock later the updated flags appear together with a one-cycle `out_valid` strobe. A flag whose enable was low for that operation keeps its earlier value. An operation that has already written a carry bit itself can mask the carry update for that bit.

Top module: `intflag_gen`

## Requirements
- R1: When `inv_a` is 1, every flag computation uses the bitwise complement of `src_a` in place of `src_a`.
- R2: When `imm_ok` is 1, `imm_data` replaces `src_b` as the second operand for every flag computation.
- R3: When `is_add` is 0, `ca` is 1 exactly when either operand is unsigned-greater than `result`. `ca32` applies the same test to bits 31:0 only.
- R4: When `is_add` is 1, `ca` follows the R3 rule and `ca32` equals `result[32] ^ opA[32] ^ opB[32]`.
- R5: `ov` is 1 when both operands have the same sign (bit 63) and the sign of `result` differs. `ov32` applies the same rule to bit 31.
- R6: When `divov_ok` is 1, both `ov` and `ov32` take the value of `divov_val` and the operand analysis is ignored.
- R7: `so` is set whenever `ov` is written as 1. Otherwise it keeps its value until reset.
- R8: With `rec_en` set, `cr` is {negative, positive, zero, so}, with negative in bit 3 and `so` in bit 0. The sign test is a signed 64-bit test on `result`, and `so` is the value written by the same operation.
- R9: `carry_done[0]` set keeps `ca` unchanged, and `carry_done[1]` set keeps `ca32` unchanged, even when `carry_en` is 1.
- R10: Flags are registered and update one cycle after `in_valid`, with `out_valid` high for exactly that cycle. Flags whose enable (`carry_en`, `ov_en`, `rec_en`) is low hold their value. Reset clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered this cycle |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| imm_data | input | 64 | Immediate value |
| imm_ok | input | 1 | Immediate replaces second operand |
| inv_a | input | 1 | Complement the first operand |
| result | input | 64 | ALU result |
| is_add | input | 1 | Operation is an add |
| carry_en | input | 1 | Update carry flags |
| carry_done | input | 2 | Bit 0: carry already written; bit 1: low-half carry already written |
| ov_en | input | 1 | Update overflow flags |
| divov_ok | input | 1 | External divide overflow is supplied |
| divov_val | input | 1 | External divide overflow value |
| rec_en | input | 1 | Update condition field |
| out_valid | output | 1 | Flags updated this cycle |
| ca | output | 1 | Carry |
| ca32 | output | 1 | Low-half carry |
| ov | output | 1 | Overflow |
| ov32 | output | 1 | Low-half overflow |
| so | output | 1 | Sticky summary overflow |
| cr | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The bench builds the block with its default width of 64. At that width the low-half boundary at bit 32 sits well inside the word. Operands can therefore be chosen so that the full-width and low-half carry or overflow disagree, in both directions. It also uses values with the top bit set, so that the signed condition test and the sign-change overflow rule are reached separately from the unsigned carry comparison.

// File: rtl/intflag_pkg.sv
package intflag_pkg;

    typedef struct packed {
        logic       vld;
        logic       ca;
        logic       ca32;
        logic       ov;
        logic       ov32;
        logic       so;
        logic [3:0] cr;
    } flag_state_t;

    localparam flag_state_t FLAG_RESET = '{vld: 1'b0, ca: 1'b0, ca32: 1'b0,
                                           ov: 1'b0, ov32: 1'b0, so: 1'b0,
                                           cr: 4'b0000};

endpackage

// File: rtl/intflag_carry.sv
module intflag_carry #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] res,
    input  logic            is_add,
    output logic            ca,
    output logic            ca32
);
    localparam int HALF   = XLEN / 2;
    localparam int NUM_OP = 2;

    logic [NUM_OP-1:0][XLEN-1:0] ops;
    logic [NUM_OP-1:0]           gt_full;
    logic [NUM_OP-1:0]           gt_half;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // One unsigned comparator pair per operand
    for (genvar g = 0; g < NUM_OP; g++) begin : g_cmp
        assign gt_full[g] = ops[g] > res;
        assign gt_half[g] = ops[g][HALF-1:0] > res[HALF-1:0];
    end

    always_comb begin
        ca = |gt_full;
        if (is_add) begin
            // carry into bit HALF recovered from the sum bit
            ca32 = res[HALF] ^ op_a[HALF] ^ op_b[HALF];
        end else begin
            ca32 = |gt_half;
        end
    end

endmodule

// File: rtl/intflag_ovf.sv
module intflag_ovf #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] res,
    input  logic            div_ok,
    input  logic            div_val,
    output logic            ov,
    output logic            ov32
);
    localparam int HALF = XLEN / 2;

    logic sgn_full_ov;
    logic sgn_half_ov;

    assign sgn_full_ov = (op_a[XLEN-1] == op_b[XLEN-1]) && (res[XLEN-1] != op_a[XLEN-1]);
    assign sgn_half_ov = (op_a[HALF-1] == op_b[HALF-1]) && (res[HALF-1] != op_a[HALF-1]);

    always_comb begin
        if (div_ok) begin
            ov   = div_val;
            ov32 = div_val;
        end else begin
            ov   = sgn_full_ov;
            ov32 = sgn_half_ov;
        end
    end

endmodule

// File: rtl/intflag_cond.sv
module intflag_cond #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] res,
    input  logic            so_in,
    output logic [3:0]      cr
);
    logic is_neg;
    logic is_zero;
    logic is_pos;

    assign is_neg  = res[XLEN-1];
    assign is_zero = (res == '0);
    assign is_pos  = !is_neg && !is_zero;

    assign cr = {is_neg, is_pos, is_zero, so_in};

endmodule

// File: rtl/intflag_gen.sv
module intflag_gen
    import intflag_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [XLEN-1:0] imm_data,
    input  logic            imm_ok,
    input  logic            inv_a,
    input  logic [XLEN-1:0] result,
    input  logic            is_add,
    input  logic            carry_en,
    input  logic [1:0]      carry_done,
    input  logic            ov_en,
    input  logic            divov_ok,
    input  logic            divov_val,
    input  logic            rec_en,
    output logic            out_valid,
    output logic            ca,
    output logic            ca32,
    output logic            ov,
    output logic            ov32,
    output logic            so,
    output logic [3:0]      cr
);
    flag_state_t     flags_d, flags_q;
    logic [XLEN-1:0] opa_d, opb_d;
    logic            ca_c, ca32_c, ov_c, ov32_c;
    logic            so_d;
    logic [3:0]      cr_c;

    // Operand preparation (R1, R2)
    assign opa_d = inv_a  ? ~src_a   : src_a;
    assign opb_d = imm_ok ? imm_data : src_b;

    intflag_carry #(.XLEN(XLEN)) i_carry (
        .op_a   (opa_d),
        .op_b   (opb_d),
        .res    (result),
        .is_add (is_add),
        .ca     (ca_c),
        .ca32   (ca32_c)
    );

    intflag_ovf #(.XLEN(XLEN)) i_ovf (
        .op_a    (opa_d),
        .op_b    (opb_d),
        .res     (result),
        .div_ok  (divov_ok),
        .div_val (divov_val),
        .ov      (ov_c),
        .ov32    (ov32_c)
    );

    // Summary bit as written by this operation feeds the condition field
    assign so_d = (in_valid && ov_en) ? (flags_q.so | ov_c) : flags_q.so;

    intflag_cond #(.XLEN(XLEN)) i_cond (
        .res   (result),
        .so_in (so_d),
        .cr    (cr_c)
    );

    always_comb begin
        flags_d     = flags_q;
        flags_d.vld = in_valid;
        if (in_valid) begin
            if (carry_en) begin
                if (!carry_done[0]) flags_d.ca   = ca_c;
                if (!carry_done[1]) flags_d.ca32 = ca32_c;
            end
            if (ov_en) begin
                flags_d.ov   = ov_c;
                flags_d.ov32 = ov32_c;
            end
            flags_d.so = so_d;
            if (rec_en) flags_d.cr = cr_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= FLAG_RESET;
        else        flags_q <= flags_d;
    end

    assign out_valid = flags_q.vld;
    assign ca        = flags_q.ca;
    assign ca32      = flags_q.ca32;
    assign ov        = flags_q.ov;
    assign ov32      = flags_q.ov32;
    assign so        = flags_q.so;
    assign cr        = flags_q.cr;

    // R10: strobe timing
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10: carry held when not enabled
    a_r10_ca_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && carry_en) |=> $stable(ca) && $stable(ca32));
    // R9: already-written carry is left alone
    a_r9_ca_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && carry_en && carry_done[0]) |=> $stable(ca));
    // R7: sticky summary
    a_r7_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        so |=> so);
    a_r7_ov_sets_so: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ov_en) |=> (!ov || so));
    // R6: divide overflow drives both overflow bits
    a_r6_div_override: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ov_en && divov_ok) |=> (ov == ov32) && (ov == $past(divov_val)));
    // R8: exactly one of neg/pos/zero, summary in bit 0
    a_r8_cr_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_en) |=> ($countones(cr[3:1]) == 1) && (cr[0] == so));

endmodule

// File: tb/test_intflag_gen.sv
module test_intflag_gen;
    localparam int  XLEN   = 64;
    localparam time CLK_PD = 10ns;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [XLEN-1:0] src_a, src_b, imm_data, result;
    logic            imm_ok, inv_a, is_add, carry_en, ov_en, divov_ok, divov_val, rec_en;
    logic [1:0]      carry_done;
    logic            out_valid, ca, ca32, ov, ov32, so;
    logic [3:0]      cr;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PD / 2) clk = ~clk;

    intflag_gen #(.XLEN(XLEN)) i_intflag_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .imm_data(imm_data), .imm_ok(imm_ok),
        .inv_a(inv_a), .result(result), .is_add(is_add), .carry_en(carry_en),
        .carry_done(carry_done), .ov_en(ov_en), .divov_ok(divov_ok),
        .divov_val(divov_val), .rec_en(rec_en), .out_valid(out_valid),
        .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so), .cr(cr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        in_valid = 0; src_a = '0; src_b = '0; imm_data = '0; result = '0;
        imm_ok = 0; inv_a = 0; is_add = 0; carry_en = 0; ov_en = 0;
        divov_ok = 0; divov_val = 0; rec_en = 0; carry_done = 2'b00;
    endtask

    task automatic do_reset();
        clear_in();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // Offer one operation, sample after the registering edge
    task automatic fire();
        @(negedge clk);
        in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        check("R10 out_valid after op", out_valid, 1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 reset valid", out_valid, 0);
        check("R10 reset flags", {ca, ca32, ov, ov32, so, cr}, 0);
    endtask

    task automatic t_plain_carry();
        clear_in(); carry_en = 1;
        src_a = 64'd5; src_b = 64'd3; result = 64'd2;
        fire();
        check("R3 ca a>res", ca, 1);
        check("R3 ca32 a>res", ca32, 1);
        clear_in(); carry_en = 1;
        src_a = 64'd1; src_b = 64'd1; result = 64'd2;
        fire();
        check("R3 ca none greater", {ca, ca32}, 2'b00);
        clear_in(); carry_en = 1;
        src_a = 64'h1_0000_0005; src_b = 0; result = 64'h2_0000_0001;
        fire();
        check("R3 low half only", {ca, ca32}, 2'b01);
        @(negedge clk);
        check("R10 strobe one cycle", out_valid, 0);
    endtask

    task automatic t_add_carry();
        clear_in(); carry_en = 1; is_add = 1;
        src_a = 64'h0000_0000_FFFF_FFFF; src_b = 64'd1; result = 64'h1_0000_0000;
        fire();
        check("R4 add ca", ca, 0);
        check("R4 add ca32 from bit32", ca32, 1);
        clear_in(); carry_en = 1; is_add = 1;
        src_a = '1; src_b = 64'd1; result = '0;
        fire();
        check("R4 add wrap", {ca, ca32}, 2'b11);
    endtask

    task automatic t_invert();
        clear_in(); carry_en = 1; result = 64'd5;
        fire();
        check("R1 no invert", ca, 0);
        clear_in(); carry_en = 1; result = 64'd5; inv_a = 1;
        fire();
        check("R1 invert a", ca, 1);
    endtask

    task automatic t_imm();
        clear_in(); carry_en = 1; result = 64'd5; imm_data = 64'd10; imm_ok = 1;
        fire();
        check("R2 imm used", ca, 1);
        clear_in(); carry_en = 1; result = 64'd5; imm_data = 64'd10;
        fire();
        check("R2 imm ignored", ca, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        clear_in(); ov_en = 1; rec_en = 1;
        src_a = 64'h7FFF_FFFF_FFFF_FFFF; src_b = 64'd1; result = 64'h8000_0000_0000_0000;
        fire();
        check("R5 ov full", {ov, ov32}, 2'b10);
        check("R7 so set", so, 1);
        check("R8 cr neg with so", cr, 4'b1001);
        clear_in(); ov_en = 1;
        src_a = 64'd1; src_b = 64'd1; result = 64'd2;
        fire();
        check("R5 no ov", {ov, ov32}, 2'b00);
        check("R7 so sticky", so, 1);
        clear_in(); ov_en = 1;
        src_a = 64'h7FFF_FFFF; src_b = 64'd1; result = 64'h8000_0000;
        fire();
        check("R5 ov32 only", {ov, ov32}, 2'b01);
    endtask

    task automatic t_div();
        clear_in(); ov_en = 1; divov_ok = 1; divov_val = 1;
        src_a = 64'd1; src_b = 64'd1; result = 64'd2;
        fire();
        check("R6 div forces 1", {ov, ov32}, 2'b11);
        clear_in(); ov_en = 1; divov_ok = 1; divov_val = 0;
        src_a = 64'h7FFF_FFFF_FFFF_FFFF; src_b = 64'd1; result = 64'h8000_0000_0000_0000;
        fire();
        check("R6 div forces 0", {ov, ov32}, 2'b00);
    endtask

    task automatic t_cond();
        do_reset();
        clear_in(); rec_en = 1; result = '0;
        fire();
        check("R8 zero", cr, 4'b0010);
        clear_in(); rec_en = 1; result = 64'd5;
        fire();
        check("R8 positive", cr, 4'b0100);
        clear_in(); result = 64'h8000_0000_0000_0000;
        fire();
        check("R10 cr held", cr, 4'b0100);
    endtask

    task automatic t_done_hold();
        clear_in(); carry_en = 1;
        src_a = 64'd5; src_b = 64'd3; result = 64'd2;
        fire();
        check("R9 setup", {ca, ca32}, 2'b11);
        clear_in(); carry_en = 1; carry_done = 2'b01;
        src_a = 64'd1; src_b = 64'd1; result = 64'd2;
        fire();
        check("R9 ca kept ca32 written", {ca, ca32}, 2'b10);
        clear_in(); carry_en = 1; carry_done = 2'b10;
        src_a = 64'd1; src_b = 64'd1; result = 64'd2;
        fire();
        check("R9 ca32 kept ca written", {ca, ca32}, 2'b00);
        clear_in(); src_a = 64'd5; result = 64'd2; ov_en = 0;
        fire();
        check("R10 carry held disabled", {ca, ca32}, 2'b00);
    endtask

    initial begin
        t_reset();
        t_plain_carry();
        t_add_carry();
        t_invert();
        t_imm();
        t_overflow();
        t_div();
        t_cond();
        t_done_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule